// File: doc/BRIEF.md
# Overcurrent Fault Response Controller

This block decides what a point-of-load converter does with its output stage when a sampled overcurrent comparison reports that the limit is exceeded. It owns the output-enable signal and a fault flag. A small configuration register, loaded through a write strobe, selects one of five reaction policies and holds a hiccup delay, a retry budget and a ride-through delay. All delays are counted in pulses of a slow timer tick that the surrounding chip provides.

The available policies are:

- Stop at once and wait for the overcurrent to go away.
- Hiccup forever.
- Hiccup a limited number of times and then stay off.
- Keep running for a grace period and stop only if the overcurrent outlasts it.
- Ignore the overcurrent entirely.

The current sensing, the converter and the host bus that writes the configuration are outside this block.

The outputs are registered. A change on the compare input shows on the outputs one clock after the edge that samples it. A retry counter reports how many restart attempts the present fault episode has used.

Top module: `ocp_fault_ctrl`

## Requirements
- R1: After reset the output is enabled, the fault flag is low, the retry count is 0 and the active policy is code 0 (immediate).
- R2: Under policy code 0, and under the unused codes 5, 6 and 7, an asserted `oc_trip` disables the output and sets the fault flag on the next clock. The output is re-enabled and the flag cleared on the clock after `oc_trip` is sampled low.
- R3: Under policy code 1 (infinite hiccup), an asserted `oc_trip` disables the output. After the programmed retry delay in ticks, a restart attempt is counted. The output comes back if `oc_trip` is low at that moment; otherwise another delay period starts. The count saturates at its maximum.
- R4: Under policy code 2 (bounded retry), hiccup attempts are made as in R3. When an attempt fails and the count reaches the programmed maximum, the output stays off. A maximum of 0 turns the output off permanently at the first trip.
- R5: A permanent shutdown (from R4 or R6) keeps the output disabled and the fault flag set whatever `oc_trip` and `tick` do. Only a configuration write or a reset ends it.
- R6: Under policy code 3 (ride-through), the output stays enabled, with the fault flag low, for the programmed ride-through delay in ticks while `oc_trip` stays high. If `oc_trip` is still high when the delay ends, the output shuts down permanently.
- R7: Under policy code 3, if `oc_trip` drops before the ride-through delay expires, the delay count is discarded. A later trip starts a full new delay.
- R8: Under policy code 4 (ignore), the output stays enabled and the fault flag low no matter how long `oc_trip` is high.
- R9: The fault flag is high exactly while the output is disabled by an overcurrent response. It clears on a successful restart. The retry count is cleared when a new hiccup episode begins and is left unchanged by a successful restart.
- R10: A `cfg_wr` pulse loads all four configuration fields. On the next clock the output is enabled, the fault flag is low and the retry count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oc_trip | input | 1 | Current-limit compare result, high when over the limit |
| tick | input | 1 | One-clock timer tick used for every delay |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_policy | input | 3 | Policy code: 0 immediate, 1 infinite hiccup, 2 bounded retry, 3 ride-through, 4 ignore |
| cfg_retry_dly | input | DLY_W | Hiccup delay in ticks |
| cfg_retry_max | input | CNT_W | Retry budget for bounded retry |
| cfg_ride_dly | input | DLY_W | Ride-through delay in ticks |
| out_en | output | 1 | Output stage enable |
| fault_flag | output | 1 | Overcurrent shutdown in effect |
| retry_cnt | output | CNT_W | Restart attempts in the current episode |

## Verification
The hardest case to reach from the ports is the end of the retry budget. It needs a trip that stays high through several complete hiccup periods, with each period's final tick placed exactly. The bench holds `oc_trip` high and issues ticks in counted bursts, checking the count after each failed attempt until the output locks off. It then lowers `oc_trip` and keeps ticking to show nothing revives the output except a configuration write. The ride-through restart is reached the same way: the trip is dropped one tick short of expiry, then reasserted for a full new delay.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  localparam logic [2:0] POL_IMM     = 3'd0;
  localparam logic [2:0] POL_HICCUP  = 3'd1;
  localparam logic [2:0] POL_BOUNDED = 3'd2;
  localparam logic [2:0] POL_RIDE    = 3'd3;
  localparam logic [2:0] POL_IGNORE  = 3'd4;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_OFF_WAIT,
    ST_HICCUP,
    ST_RIDE,
    ST_LATCH
  } ocp_state_e;

endpackage

// File: rtl/ocp_tick_timer.sv
module ocp_tick_timer #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic [DW-1:0] limit,
  output logic          done
);
  localparam logic [DW-1:0] TOP = {DW{1'b1}};

  logic [DW-1:0] count;

  always_ff @(posedge clk) begin
    if (rst || clr)                 count <= '0;
    else if (tick && count != TOP)  count <= count + 1'b1;
  end

  assign done = (count >= limit);

  AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (count == TOP && !clr) |=> (count == TOP)); // R3
  AST_TIMER_CLEARS: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0)); // R7
endmodule

// File: rtl/ocp_retry_ctr.sv
module ocp_retry_ctr #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr)              cnt <= '0;
    else if (inc && cnt != TOP)  cnt <= cnt + 1'b1;
  end

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (cnt == TOP && !clr) |=> (cnt == TOP)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!clr && !inc) |=> $stable(cnt)); // R9
endmodule

// File: rtl/ocp_fault_ctrl.sv
module ocp_fault_ctrl
  import ocp_pkg::*;
#(
  parameter int              DLY_W         = 16,
  parameter int              CNT_W         = 8,
  parameter logic [DLY_W-1:0] DEF_RETRY_DLY = 100,
  parameter logic [CNT_W-1:0] DEF_RETRY_MAX = 3,
  parameter logic [DLY_W-1:0] DEF_RIDE_DLY  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             oc_trip,
  input  logic             tick,
  input  logic             cfg_wr,
  input  logic [2:0]       cfg_policy,
  input  logic [DLY_W-1:0] cfg_retry_dly,
  input  logic [CNT_W-1:0] cfg_retry_max,
  input  logic [DLY_W-1:0] cfg_ride_dly,
  output logic             out_en,
  output logic             fault_flag,
  output logic [CNT_W-1:0] retry_cnt
);

  logic [2:0]       pol_q;
  logic [DLY_W-1:0] rdly_q;
  logic [CNT_W-1:0] rmax_q;
  logic [DLY_W-1:0] ride_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q  <= POL_IMM;
      rdly_q <= DEF_RETRY_DLY;
      rmax_q <= DEF_RETRY_MAX;
      ride_q <= DEF_RIDE_DLY;
    end else if (cfg_wr) begin
      pol_q  <= cfg_policy;
      rdly_q <= cfg_retry_dly;
      rmax_q <= cfg_retry_max;
      ride_q <= cfg_ride_dly;
    end
  end

  ocp_state_e       st, nxt;
  logic             t_clr, t_done, t_tick;
  logic             c_clr, c_inc;
  logic [DLY_W-1:0] t_limit;
  logic [CNT_W:0]   cnt_plus;

  assign t_tick   = tick && (st == ST_HICCUP || st == ST_RIDE);
  assign t_limit  = (st == ST_RIDE) ? ride_q : rdly_q;
  assign cnt_plus = {1'b0, retry_cnt} + 1'b1;

  ocp_tick_timer #(.DW(DLY_W)) u_timer (
    .clk(clk), .rst(rst), .clr(t_clr), .tick(t_tick),
    .limit(t_limit), .done(t_done)
  );

  ocp_retry_ctr #(.CW(CNT_W)) u_retry (
    .clk(clk), .rst(rst), .clr(c_clr), .inc(c_inc), .cnt(retry_cnt)
  );

  always_comb begin
    nxt   = st;
    t_clr = 1'b0;
    c_clr = 1'b0;
    c_inc = 1'b0;
    if (cfg_wr) begin
      nxt   = ST_RUN;
      t_clr = 1'b1;
      c_clr = 1'b1;
    end else begin
      case (st)
        ST_RUN: if (oc_trip) begin
          t_clr = 1'b1;
          case (pol_q)
            POL_HICCUP: begin
              nxt   = ST_HICCUP;
              c_clr = 1'b1;
            end
            POL_BOUNDED: begin
              c_clr = 1'b1;
              nxt   = (rmax_q == '0) ? ST_LATCH : ST_HICCUP;
            end
            POL_RIDE:   nxt = ST_RIDE;
            POL_IGNORE: nxt = ST_RUN;
            default:    nxt = ST_OFF_WAIT;
          endcase
        end
        ST_OFF_WAIT: if (!oc_trip) nxt = ST_RUN;
        ST_HICCUP: if (t_done) begin
          t_clr = 1'b1;
          c_inc = 1'b1;
          if (!oc_trip)
            nxt = ST_RUN;
          else if (pol_q == POL_BOUNDED && cnt_plus >= {1'b0, rmax_q})
            nxt = ST_LATCH;
        end
        ST_RIDE: begin
          if (!oc_trip) begin
            nxt   = ST_RUN;
            t_clr = 1'b1;
          end else if (t_done) begin
            nxt = ST_LATCH;
          end
        end
        default: nxt = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_RUN;
      out_en     <= 1'b1;
      fault_flag <= 1'b0;
    end else begin
      st         <= nxt;
      out_en     <= (nxt == ST_RUN) || (nxt == ST_RIDE);
      fault_flag <= (nxt == ST_OFF_WAIT) || (nxt == ST_HICCUP) || (nxt == ST_LATCH);
    end
  end

  AST_IMM_CUTS: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && oc_trip && !cfg_wr && (pol_q == POL_IMM || pol_q > POL_IGNORE))
      |=> (!out_en && fault_flag)); // R2
  AST_BOUNDED_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HICCUP && pol_q == POL_BOUNDED) |-> (retry_cnt < rmax_q)); // R4
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LATCH && !cfg_wr) |=> (st == ST_LATCH && !out_en && fault_flag)); // R5
  AST_RIDE_ON: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RIDE) |-> (out_en && !fault_flag)); // R6
  AST_IGNORE_ON: assert property (@(posedge clk) disable iff (rst)
    (pol_q == POL_IGNORE && !cfg_wr) |=> out_en); // R8
  AST_FLAG_MEANS_OFF: assert property (@(posedge clk) disable iff (rst)
    fault_flag |-> !out_en); // R9
  AST_CFG_RESUMES: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> (out_en && !fault_flag && retry_cnt == '0)); // R10
endmodule

// File: tb/sim_ocp_fault_ctrl.sv
module sim_ocp_fault_ctrl;
  localparam int DW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          oc_trip = 1'b0;
  logic          tick = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [2:0]    cfg_policy = '0;
  logic [DW-1:0] cfg_retry_dly = '0;
  logic [CW-1:0] cfg_retry_max = '0;
  logic [DW-1:0] cfg_ride_dly = '0;
  logic          out_en, fault_flag;
  logic [CW-1:0] retry_cnt;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ocp_fault_ctrl #(.DLY_W(DW), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .oc_trip(oc_trip), .tick(tick), .cfg_wr(cfg_wr),
    .cfg_policy(cfg_policy), .cfg_retry_dly(cfg_retry_dly),
    .cfg_retry_max(cfg_retry_max), .cfg_ride_dly(cfg_ride_dly),
    .out_en(out_en), .fault_flag(fault_flag), .retry_cnt(retry_cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int en, input int flt, input int cnt);
    chk({req, " out_en"}, int'(out_en), en);
    chk({req, " fault_flag"}, int'(fault_flag), flt);
    chk({req, " retry_cnt"}, int'(retry_cnt), cnt);
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic write_cfg(input logic [2:0] pol, input int rdly, input int rmax, input int ride);
    @(negedge clk);
    oc_trip       = 1'b0;
    cfg_policy    = pol;
    cfg_retry_dly = DW'(rdly);
    cfg_retry_max = CW'(rmax);
    cfg_ride_dly  = DW'(ride);
    cfg_wr        = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk_out("R1 reset", 1, 0, 0);
    oc_trip = 1'b1;
    cyc(1);
    chk_out("R1 default policy immediate", 0, 1, 0);
    oc_trip = 1'b0;
    cyc(1);
  endtask

  task automatic t_immediate(input logic [2:0] code);
    write_cfg(code, 2, 2, 2);
    oc_trip = 1'b1;
    cyc(1);
    chk_out("R2 trip", 0, 1, 0);
    ticks(5);
    chk_out("R2 held off", 0, 1, 0);
    oc_trip = 1'b0;
    cyc(1);
    chk_out("R2 re-enable", 1, 0, 0);
  endtask

  task automatic t_hiccup;
    write_cfg(3'd1, 3, 0, 0);
    oc_trip = 1'b1;
    cyc(1);
    chk_out("R3 off", 0, 1, 0);
    ticks(2);
    chk_out("R3 waiting", 0, 1, 0);
    ticks(1);
    cyc(1);
    chk_out("R3 failed attempt", 0, 1, 1);
    ticks(3);
    cyc(1);
    chk_out("R3 second failure", 0, 1, 2);
    oc_trip = 1'b0;
    ticks(3);
    cyc(1);
    chk_out("R9 successful restart", 1, 0, 3);
    oc_trip = 1'b1;
    cyc(1);
    chk_out("R9 new episode clears count", 0, 1, 0);
    oc_trip = 1'b0;
  endtask

  task automatic t_hiccup_sat;
    write_cfg(3'd1, 0, 0, 0);
    oc_trip = 1'b1;
    cyc(300);
    chk_out("R3 count saturates", 0, 1, 255);
    oc_trip = 1'b0;
    cyc(2);
    chk_out("R3 restart after saturation", 1, 0, 255);
  endtask

  task automatic t_bounded;
    write_cfg(3'd2, 1, 2, 0);
    chk_out("R10 after write", 1, 0, 0);
    oc_trip = 1'b1;
    cyc(1);
    chk_out("R4 first trip", 0, 1, 0);
    ticks(1);
    cyc(1);
    chk_out("R4 attempt 1 failed", 0, 1, 1);
    ticks(1);
    cyc(1);
    chk_out("R4 budget spent", 0, 1, 2);
    oc_trip = 1'b0;
    ticks(6);
    cyc(3);
    chk_out("R5 stays latched", 0, 1, 2);
    write_cfg(3'd2, 1, 0, 0);
    chk_out("R10 write releases latch", 1, 0, 0);
    oc_trip = 1'b1;
    cyc(1);
    chk_out("R4 zero budget", 0, 1, 0);
    oc_trip = 1'b0;
    ticks(4);
    chk_out("R5 zero budget latched", 0, 1, 0);
    write_cfg(3'd2, 2, 3, 0);
    oc_trip = 1'b1;
    cyc(1);
    ticks(2);
    cyc(1);
    chk_out("R4 attempt counted", 0, 1, 1);
    oc_trip = 1'b0;
    ticks(2);
    cyc(1);
    chk_out("R4 restart within budget", 1, 0, 2);
  endtask

  task automatic t_ride;
    write_cfg(3'd3, 0, 0, 4);
    oc_trip = 1'b1;
    cyc(1);
    ticks(3);
    chk_out("R6 riding", 1, 0, 0);
    oc_trip = 1'b0;
    cyc(1);
    oc_trip = 1'b1;
    cyc(1);
    ticks(3);
    chk_out("R7 timer restarted", 1, 0, 0);
    ticks(1);
    cyc(1);
    chk_out("R6 expiry shuts down", 0, 1, 0);
    oc_trip = 1'b0;
    ticks(3);
    chk_out("R5 ride latch holds", 0, 1, 0);
  endtask

  task automatic t_ignore;
    write_cfg(3'd4, 0, 0, 0);
    oc_trip = 1'b1;
    ticks(10);
    chk_out("R8 ignore", 1, 0, 0);
    oc_trip = 1'b0;
    cyc(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    t_reset();
    t_immediate(3'd0);
    t_immediate(3'd6);
    t_hiccup();
    t_hiccup_sat();
    t_bounded();
    t_ride();
    t_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule